// File: doc/BRIEF.md
# Open-Row Conflict Evaluator

This block sits between a request source and the command issue logic of a DRAM controller. Each request names a bank, a row, a direction and a conflict hint. The hint is pessimistic: the source raises it whenever the bank or row differs from its previous request. The evaluator keeps one valid bit and one row address per bank, and compares each flagged request against that table. A flagged request whose row is already open is a false alarm. It is issued at once as a read or write. A flagged request whose row is not open stalls the request port, issues an activate for that bank and row, waits a fixed gap, issues the access, and then reopens the port. A request without the hint is taken to hit the open row and is issued directly.

Requests use a valid/ready handshake. A request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the source must hold the request stable. The command port is a plain one-cycle strobe with no back-pressure. The precharge inputs are plain control pins. Each one closes one bank, or all banks, on the edge where it is sampled.

Top module: `open_row_evaluator`

## Requirements
- R1: After reset `req_ready` is high, `cmd_valid` is low and every bank is marked closed, so the first flagged request to any bank is treated as a miss.
- R2: A request accepted with `req_hint` low produces, two cycles after its accepting edge, one command with op 2'b10 (read, `req_write`=0) or 2'b11 (write, `req_write`=1) carrying its bank and row, with no activate and no drop of `req_ready`.
- R3: A request accepted with `req_hint` high whose row is recorded open in its bank is a false conflict: it is issued exactly as in R2, and `req_ready` stays high.
- R4: A request accepted with `req_hint` high whose bank is closed or holds another row produces an activate (op 2'b01) with its bank and row two cycles after acceptance, then the read or write to the same bank and row `ACT_GAP` cycles after the activate.
- R5: For a real conflict, `req_ready` is low from the cycle the activate appears until the cycle the access appears, and it is high again in that cycle.
- R6: An activate marks its row open in its bank only. Rows opened in different banks stay open together, and a later flagged return to any of them is a false conflict.
- R7: An activate to a bank that holds a different row replaces the recorded row, so a flagged request to the old row is then a miss.
- R8: A sampled precharge with `prech_all` low closes bank `prech_bank`; with `prech_all` high it closes every bank. A precharge sampled in the same cycle a flagged request is judged makes that request a miss.
- R9: A request accepted in the cycle after a real-conflict request is held and issued after that conflict's access, so commands leave in acceptance order. It is judged against the table as updated by the activate.
- R10: `cmd_valid` is high for one cycle per command, and `cmd_op` is never 2'b00 while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Evaluator can take a request |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hint | input | 1 | Upstream conflict hint |
| prech_valid | input | 1 | Close a bank this cycle |
| prech_all | input | 1 | With prech_valid, close every bank |
| prech_bank | input | BANK_W | Bank to close |
| cmd_valid | output | 1 | Command strobe |
| cmd_op | output | 2 | 01 activate, 10 read, 11 write |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |

## Verification
The assertions check the stall protocol on every cycle. An activate never coincides with high ready. Ready stays low while an activate waits for its access, and it rises only together with an access. Each activate is followed by an access to the same bank and row before any further activate, and every command has a legal op. The hit-or-miss verdict itself depends on table history: false conflicts, overwrites, banks held open side by side, precharge clearing, and ordering behind a stall. Only the bench's directed scenarios show that verdict, because they know which rows were opened and closed earlier.

// File: rtl/ore_pkg.sv
package ore_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_ACT   = 2'b01,
    OP_READ  = 2'b10,
    OP_WRITE = 2'b11
  } cmd_op_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_HOLD = 1'b1
  } seq_state_e;
endpackage

// File: rtl/ore_row_table.sv
module ore_row_table #(
  parameter int BANKS  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] lk_bank,
  input  logic [ROW_W-1:0]  lk_row,
  output logic              lk_hit,
  input  logic              set_en,
  input  logic [BANK_W-1:0] set_bank,
  input  logic [ROW_W-1:0]  set_row,
  input  logic              clr_en,
  input  logic              clr_all,
  input  logic [BANK_W-1:0] clr_bank
);
  logic [BANKS-1:0] open_q;
  logic [BANKS-1:0] kill;
  logic [ROW_W-1:0] row_q [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    assign kill[g] = clr_en && (clr_all || clr_bank == BANK_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[g] <= 1'b0;
      end else if (set_en && set_bank == BANK_W'(g)) begin
        open_q[g] <= 1'b1;
      end else if (kill[g]) begin
        open_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (set_en && set_bank == BANK_W'(g)) row_q[g] <= set_row;
    end
  end

  // a bank being closed this cycle no longer counts as open
  always_comb begin
    lk_hit = 1'b0;
    for (int i = 0; i < BANKS; i++) begin
      if (lk_bank == BANK_W'(i))
        lk_hit = open_q[i] && !kill[i] && (row_q[i] == lk_row);
    end
  end
endmodule

// File: rtl/ore_req_stage.sv
module ore_req_stage #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  input  logic              in_write,
  input  logic              in_hint,
  input  logic              consume,
  output logic              s_valid,
  output logic [BANK_W-1:0] s_bank,
  output logic [ROW_W-1:0]  s_row,
  output logic              s_write,
  output logic              s_hint
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
    end else if (take) begin
      s_valid <= 1'b1;
    end else if (consume) begin
      s_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      s_bank  <= in_bank;
      s_row   <= in_row;
      s_write <= in_write;
      s_hint  <= in_hint;
    end
  end
endmodule

// File: rtl/ore_sequencer.sv
module ore_sequencer
  import ore_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 14,
  parameter int ACT_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [BANK_W-1:0] s_bank,
  input  logic [ROW_W-1:0]  s_row,
  input  logic              s_write,
  input  logic              s_hint,
  input  logic              hit,
  output logic              consume,
  output logic              ready,
  output logic              act_en,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row
);
  localparam int CW = (ACT_GAP > 1) ? $clog2(ACT_GAP) : 1;

  seq_state_e        state;
  logic [CW-1:0]     gap_cnt;
  logic [BANK_W-1:0] h_bank;
  logic [ROW_W-1:0]  h_row;
  logic              h_write;
  logic              miss;

  assign ready   = (state == SEQ_IDLE);
  assign consume = ready && s_valid;
  assign miss    = s_hint && !hit;
  assign act_en  = consume && miss;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      gap_cnt   <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NONE;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      h_bank    <= '0;
      h_row     <= '0;
      h_write   <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (s_valid) begin
            cmd_valid <= 1'b1;
            cmd_bank  <= s_bank;
            cmd_row   <= s_row;
            if (miss) begin
              cmd_op  <= OP_ACT;
              h_bank  <= s_bank;
              h_row   <= s_row;
              h_write <= s_write;
              gap_cnt <= CW'(ACT_GAP - 1);
              state   <= SEQ_HOLD;
            end else begin
              cmd_op  <= s_write ? OP_WRITE : OP_READ;
            end
          end
        end
        SEQ_HOLD: begin
          if (gap_cnt == '0) begin
            cmd_valid <= 1'b1;
            cmd_op    <= h_write ? OP_WRITE : OP_READ;
            cmd_bank  <= h_bank;
            cmd_row   <= h_row;
            state     <= SEQ_IDLE;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/open_row_evaluator.sv
module open_row_evaluator #(
  parameter int BANKS   = 4,
  parameter int ROW_W   = 14,
  parameter int ACT_GAP = 2,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic              req_write,
  input  logic              req_hint,
  input  logic              prech_valid,
  input  logic              prech_all,
  input  logic [BANK_W-1:0] prech_bank,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row
);
  logic              s_valid, s_write, s_hint;
  logic [BANK_W-1:0] s_bank;
  logic [ROW_W-1:0]  s_row;
  logic              hit, consume, act_en;

  ore_req_stage #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .take(req_valid && req_ready),
    .in_bank(req_bank), .in_row(req_row), .in_write(req_write), .in_hint(req_hint),
    .consume(consume),
    .s_valid(s_valid), .s_bank(s_bank), .s_row(s_row), .s_write(s_write), .s_hint(s_hint)
  );

  ore_row_table #(.BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .lk_bank(s_bank), .lk_row(s_row), .lk_hit(hit),
    .set_en(act_en), .set_bank(s_bank), .set_row(s_row),
    .clr_en(prech_valid), .clr_all(prech_all), .clr_bank(prech_bank)
  );

  ore_sequencer #(.BANK_W(BANK_W), .ROW_W(ROW_W), .ACT_GAP(ACT_GAP)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_bank(s_bank), .s_row(s_row), .s_write(s_write), .s_hint(s_hint),
    .hit(hit), .consume(consume), .ready(req_ready), .act_en(act_en),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row)
  );
endmodule

// File: rtl/ore_checker.sv
module ore_checker #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row
);
  logic              pend;
  logic [BANK_W-1:0] pend_bank;
  logic [ROW_W-1:0]  pend_row;
  logic              is_act;

  assign is_act = cmd_valid && (cmd_op == 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_bank <= '0;
      pend_row  <= '0;
    end else if (is_act) begin
      pend      <= 1'b1;
      pend_bank <= cmd_bank;
      pend_row  <= cmd_row;
    end else if (cmd_valid) begin
      pend <= 1'b0;
    end
  end

  assert_act_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !req_ready);

  assert_stall_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !cmd_valid) |-> !req_ready);

  assert_ready_returns_with_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> (cmd_valid && cmd_op[1]));

  assert_access_follows_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && cmd_valid) |-> (cmd_op[1] && cmd_bank == pend_bank && cmd_row == pend_row));

  assert_no_double_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !pend);

  assert_legal_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op != 2'b00));
endmodule

bind open_row_evaluator ore_checker #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_ore_checker (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row)
);

// File: tb/open_row_evaluator_test.sv
module open_row_evaluator_test;
  localparam int BANKS = 4;
  localparam int ROW_W = 14;
  localparam int GAP   = 2;
  localparam int BW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_hint = 1'b0;
  logic [BW-1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic prech_valid = 1'b0, prech_all = 1'b0;
  logic [BW-1:0] prech_bank = '0;
  logic req_ready, cmd_valid;
  logic [1:0] cmd_op;
  logic [BW-1:0] cmd_bank;
  logic [ROW_W-1:0] cmd_row;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  open_row_evaluator #(.BANKS(BANKS), .ROW_W(ROW_W), .ACT_GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank), .req_row(req_row),
    .req_write(req_write), .req_hint(req_hint),
    .prech_valid(prech_valid), .prech_all(prech_all), .prech_bank(prech_bank),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_ready(input logic exp, input string tag);
    checks++;
    if (req_ready !== exp) begin
      fails++;
      $display("FAIL %s: req_ready got %0b expected %0b", tag, req_ready, exp);
    end
  endtask

  task automatic chk_cmd(input logic ev, input logic [1:0] eop, input logic [BW-1:0] eb,
                         input logic [ROW_W-1:0] er, input string tag);
    logic [ROW_W+BW+2:0] got, exp;
    got = {cmd_valid, cmd_op, cmd_bank, cmd_row};
    exp = {ev, eop, eb, er};
    if (!ev) begin
      got = {cmd_valid, {(ROW_W+BW+2){1'b0}}};
      exp = '0;
    end
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: cmd got %0h expected %0h", tag, got, exp);
    end
  endtask

  // drives one request for one cycle; returns at the negedge after acceptance
  task automatic send(input logic [BW-1:0] b, input logic [ROW_W-1:0] r,
                      input logic w, input logic h);
    req_valid = 1'b1; req_bank = b; req_row = r; req_write = w; req_hint = h;
    step();
    req_valid = 1'b0; req_hint = 1'b0;
  endtask

  task automatic expect_hit(input logic [BW-1:0] b, input logic [ROW_W-1:0] r,
                            input logic w, input string tag);
    chk_ready(1'b1, tag);
    step();
    chk_cmd(1'b1, w ? 2'b11 : 2'b10, b, r, tag);
    chk_ready(1'b1, tag);
  endtask

  task automatic expect_miss(input logic [BW-1:0] b, input logic [ROW_W-1:0] r,
                             input logic w, input string tag);
    step();
    chk_cmd(1'b1, 2'b01, b, r, {tag, " activate"});
    chk_ready(1'b0, {tag, " R5 stall"});
    for (int i = 0; i < GAP - 1; i++) begin
      step();
      chk_cmd(1'b0, 2'b00, '0, '0, {tag, " gap"});
      chk_ready(1'b0, {tag, " R5 stall"});
    end
    step();
    chk_cmd(1'b1, w ? 2'b11 : 2'b10, b, r, {tag, " access"});
    chk_ready(1'b1, {tag, " R5 ready back"});
  endtask

  task automatic prech(input logic all, input logic [BW-1:0] b);
    prech_valid = 1'b1; prech_all = all; prech_bank = b;
    step();
    prech_valid = 1'b0; prech_all = 1'b0;
  endtask

  task automatic t_reset();
    chk_ready(1'b1, "R1 ready after reset");
    chk_cmd(1'b0, 2'b00, '0, '0, "R1 no command after reset");
    send(2'd3, 14'd40, 1'b0, 1'b1);
    expect_miss(2'd3, 14'd40, 1'b0, "R1 empty table miss R4");
  endtask

  task automatic t_no_hint();
    send(2'd2, 14'd5, 1'b0, 1'b0);
    expect_hit(2'd2, 14'd5, 1'b0, "R2 read no hint");
    send(2'd1, 14'd77, 1'b1, 1'b0);
    expect_hit(2'd1, 14'd77, 1'b1, "R2 write no hint");
    // back-to-back unhinted requests issue on consecutive cycles
    req_valid = 1'b1; req_bank = 2'd0; req_row = 14'd9; req_write = 1'b1; req_hint = 1'b0;
    step();
    req_bank = 2'd1; req_row = 14'd10; req_write = 1'b0;
    step();
    req_valid = 1'b0;
    chk_cmd(1'b1, 2'b11, 2'd0, 14'd9, "R2 stream first");
    step();
    chk_cmd(1'b1, 2'b10, 2'd1, 14'd10, "R2 stream second");
  endtask

  task automatic t_real_then_fake();
    send(2'd2, 14'd5, 1'b1, 1'b1);
    expect_miss(2'd2, 14'd5, 1'b1, "R4 real conflict");
    send(2'd2, 14'd5, 1'b0, 1'b1);
    expect_hit(2'd2, 14'd5, 1'b0, "R3 false conflict");
  endtask

  task automatic t_banks();
    send(2'd0, 14'd1, 1'b1, 1'b1);
    expect_miss(2'd0, 14'd1, 1'b1, "R6 open bank0");
    send(2'd1, 14'd3, 1'b0, 1'b1);
    expect_miss(2'd1, 14'd3, 1'b0, "R6 open bank1");
    send(2'd0, 14'd1, 1'b0, 1'b1);
    expect_hit(2'd0, 14'd1, 1'b0, "R6 return bank0");
    send(2'd1, 14'd3, 1'b1, 1'b1);
    expect_hit(2'd1, 14'd3, 1'b1, "R6 return bank1");
  endtask

  task automatic t_overwrite();
    send(2'd0, 14'd9, 1'b0, 1'b1);
    expect_miss(2'd0, 14'd9, 1'b0, "R7 new row bank0");
    send(2'd0, 14'd1, 1'b0, 1'b1);
    expect_miss(2'd0, 14'd1, 1'b0, "R7 old row replaced");
  endtask

  task automatic t_precharge();
    prech(1'b0, 2'd1);
    send(2'd1, 14'd3, 1'b0, 1'b1);
    expect_miss(2'd1, 14'd3, 1'b0, "R8 single bank closed");
    send(2'd0, 14'd1, 1'b1, 1'b1);
    expect_hit(2'd0, 14'd1, 1'b1, "R8 other bank untouched");
    prech(1'b1, 2'd0);
    send(2'd0, 14'd1, 1'b0, 1'b1);
    expect_miss(2'd0, 14'd1, 1'b0, "R8 all closed bank0");
    send(2'd2, 14'd5, 1'b0, 1'b1);
    expect_miss(2'd2, 14'd5, 1'b0, "R8 all closed bank2");
  endtask

  task automatic t_same_cycle_prech();
    send(2'd2, 14'd5, 1'b1, 1'b1);
    prech_valid = 1'b1; prech_all = 1'b0; prech_bank = 2'd2;
    step();
    prech_valid = 1'b0;
    chk_cmd(1'b1, 2'b01, 2'd2, 14'd5, "R8 same-cycle precharge forces miss");
    chk_ready(1'b0, "R8 R5 stall");
    for (int i = 0; i < GAP - 1; i++) step();
    step();
    chk_cmd(1'b1, 2'b11, 2'd2, 14'd5, "R8 access after reopen");
  endtask

  task automatic t_order();
    send(2'd3, 14'd7, 1'b0, 1'b1);
    send(2'd3, 14'd7, 1'b1, 1'b1);
    chk_cmd(1'b1, 2'b01, 2'd3, 14'd7, "R9 activate first");
    chk_ready(1'b0, "R9 stall");
    for (int i = 0; i < GAP - 1; i++) step();
    step();
    chk_cmd(1'b1, 2'b10, 2'd3, 14'd7, "R9 first access");
    step();
    chk_cmd(1'b1, 2'b11, 2'd3, 14'd7, "R9 held request hits after activate");
    chk_ready(1'b1, "R9 ready");
    step();
    chk_cmd(1'b0, 2'b00, '0, '0, "R10 single-cycle strobe");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_hint();
    t_real_then_fake();
    t_banks();
    t_overwrite();
    t_precharge();
    t_same_cycle_prech();
    t_order();
    repeat (2) step();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule